// File: doc/BRIEF.md
# Debug Breakpoint and Watchpoint Unit

This unit watches a processor's instruction fetch address and its data accesses and raises debug exceptions when either one reaches an address that software has armed. It holds a bank of instruction breakpoint slots and a bank of data watchpoint slots. Each breakpoint slot stores an address and an armed bit. Each watchpoint slot stores a single byte address and a two-bit kind that selects which access directions it reacts to.

Software programs a slot through a one-cycle write port. The port carries a bank select, a slot index, an address and a kind. Writing kind 0 to a slot disarms it, and doing so on a slot that was never armed leaves every other slot as it was. A matching data access is flagged in the same cycle on `accessStall`, so the core can cancel the access before it takes effect. The registered hit pulses follow one cycle later. When a watchpoint hit and a breakpoint hit happen in the same cycle, only the watchpoint is reported.

Top module: `dbg_match_unit`

## Requirements
- R1: After reset every slot is disarmed, and `bpHit`, `wpHit` and `accessStall` are 0, whatever fetch address or data access is presented.
- R2: When `pcValid` is 1 and `pc` equals the address of an armed breakpoint slot, `bpHit` is 1 for exactly the next cycle. Without another such match it returns to 0.
- R3: A configuration write with `cfgSel`=0 and `cfgKind`=0 disarms the indexed breakpoint slot. Disarming a slot that was never armed does not change any other slot.
- R4: The watchpoint kind encoding is 0 = disabled, 1 = reads only, 2 = writes only, 3 = reads and writes. An access is a write when `memWrite`=1. A slot matches only accesses whose direction its kind allows.
- R5: A match requires the full address to be equal. An address one byte above or one byte below the programmed address does not match.
- R6: `accessStall` is 1 in the same cycle as a strobed access that matches an armed watchpoint, with no register in the path.
- R7: A cycle with `accessStall`=1 is followed by `wpHit`=1 for exactly one cycle.
- R8: If a watchpoint match and a breakpoint match occur in the same cycle, `wpHit` is 1 and `bpHit` stays 0.
- R9: With `memStrobe`=0 no watchpoint matches. With `pcValid`=0 no breakpoint matches.
- R10: A configuration write takes effect from the cycle after its clock edge. Comparisons in the write cycle itself use the old slot contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Slot write strobe |
| cfgSel | input | 1 | Bank select: 0 breakpoints, 1 watchpoints |
| cfgIdx | input | IDX_W | Slot index within the bank |
| cfgAddr | input | ADDR_W | Address to store in the slot |
| cfgKind | input | 2 | Watchpoint kind; for breakpoints, nonzero arms and zero disarms |
| pcValid | input | 1 | Fetch address is valid this cycle |
| pc | input | ADDR_W | Instruction fetch address |
| memStrobe | input | 1 | Data access present this cycle |
| memAddr | input | ADDR_W | Data byte address |
| memWrite | input | 1 | 1 for a write, 0 for a read |
| accessStall | output | 1 | Same-cycle watchpoint match; the access must be suppressed |
| bpHit | output | 1 | Registered breakpoint exception pulse |
| wpHit | output | 1 | Registered watchpoint exception pulse |

## Verification
`accessStall` is combinational, so it is due in the same cycle as the access it flags. `bpHit` and `wpHit` are due one clock edge after the fetch or access that causes them, and a configuration write is visible to comparisons one edge after it is issued. The bench drives inputs on the falling edge and samples `accessStall` 1 ns later. It samples the hit pulses at the next falling edge, after exactly one rising edge. A following idle cycle confirms that each pulse lasts a single cycle.

// File: rtl/dbg_match_pkg.sv
package dbg_match_pkg;
  // bit 0 enables reads, bit 1 enables writes
  typedef enum logic [1:0] {
    KIND_OFF   = 2'b00,
    KIND_READ  = 2'b01,
    KIND_WRITE = 2'b10,
    KIND_BOTH  = 2'b11
  } wp_kind_t;

  typedef struct packed {
    logic bpLoad;
    logic wpLoad;
  } cfg_strobe_t;
endpackage

// File: rtl/dbg_match_dp.sv
module dbg_match_dp
  import dbg_match_pkg::*;
#(
  parameter int NUM_BP = 4,
  parameter int NUM_WP = 4,
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cfg_strobe_t       stb,
  input  logic [IDX_W-1:0]  cfgIdx,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [1:0]        cfgKind,
  input  logic              pcValid,
  input  logic [ADDR_W-1:0] pc,
  input  logic              memStrobe,
  input  logic [ADDR_W-1:0] memAddr,
  input  logic              memWrite,
  output logic [NUM_BP-1:0] bpMatch,
  output logic [NUM_WP-1:0] wpMatch
);
  logic [ADDR_W-1:0] bpAddr [NUM_BP];
  logic [NUM_BP-1:0] bpArmed;
  logic [ADDR_W-1:0] wpAddr [NUM_WP];
  wp_kind_t          wpKind [NUM_WP];

  for (genvar g = 0; g < NUM_BP; g++) begin : g_bp
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        bpAddr[g]  <= '0;
        bpArmed[g] <= 1'b0;
      end else if (stb.bpLoad && cfgIdx == IDX_W'(g)) begin
        bpAddr[g]  <= cfgAddr;
        bpArmed[g] <= (cfgKind != 2'b00);
      end
    end
    assign bpMatch[g] = pcValid && bpArmed[g] && (pc == bpAddr[g]);
  end

  for (genvar g = 0; g < NUM_WP; g++) begin : g_wp
    logic dirOk;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        wpAddr[g] <= '0;
        wpKind[g] <= KIND_OFF;
      end else if (stb.wpLoad && cfgIdx == IDX_W'(g)) begin
        wpAddr[g] <= cfgAddr;
        wpKind[g] <= wp_kind_t'(cfgKind);
      end
    end
    assign dirOk      = memWrite ? wpKind[g][1] : wpKind[g][0];
    assign wpMatch[g] = memStrobe && dirOk && (memAddr == wpAddr[g]);
  end
endmodule

// File: rtl/dbg_match_ctl.sv
module dbg_match_ctl
  import dbg_match_pkg::*;
#(
  parameter int NUM_BP = 4,
  parameter int NUM_WP = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfgWe,
  input  logic              cfgSel,
  input  logic [NUM_BP-1:0] bpMatch,
  input  logic [NUM_WP-1:0] wpMatch,
  output cfg_strobe_t       stb,
  output logic              accessStall,
  output logic              bpHit,
  output logic              wpHit
);
  logic anyBp, anyWp;

  assign stb.bpLoad  = cfgWe && !cfgSel;
  assign stb.wpLoad  = cfgWe && cfgSel;
  assign anyBp       = |bpMatch;
  assign anyWp       = |wpMatch;
  assign accessStall = anyWp;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bpHit <= 1'b0;
      wpHit <= 1'b0;
    end else begin
      wpHit <= anyWp;
      bpHit <= anyBp && !anyWp;  // watchpoint wins
    end
  end
endmodule

// File: rtl/dbg_match_unit.sv
module dbg_match_unit
  import dbg_match_pkg::*;
#(
  parameter int NUM_BP = 4,
  parameter int NUM_WP = 4,
  parameter int ADDR_W = 32,
  parameter int IDX_W  = $clog2((NUM_BP > NUM_WP) ? NUM_BP : NUM_WP)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfgWe,
  input  logic              cfgSel,
  input  logic [IDX_W-1:0]  cfgIdx,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [1:0]        cfgKind,
  input  logic              pcValid,
  input  logic [ADDR_W-1:0] pc,
  input  logic              memStrobe,
  input  logic [ADDR_W-1:0] memAddr,
  input  logic              memWrite,
  output logic              accessStall,
  output logic              bpHit,
  output logic              wpHit
);
  cfg_strobe_t       stb;
  logic [NUM_BP-1:0] bpMatch;
  logic [NUM_WP-1:0] wpMatch;

  dbg_match_ctl #(.NUM_BP(NUM_BP), .NUM_WP(NUM_WP)) u_ctl (
    .clk(clk), .rst_n(rst_n), .cfgWe(cfgWe), .cfgSel(cfgSel),
    .bpMatch(bpMatch), .wpMatch(wpMatch), .stb(stb),
    .accessStall(accessStall), .bpHit(bpHit), .wpHit(wpHit)
  );

  dbg_match_dp #(.NUM_BP(NUM_BP), .NUM_WP(NUM_WP), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb), .cfgIdx(cfgIdx), .cfgAddr(cfgAddr),
    .cfgKind(cfgKind), .pcValid(pcValid), .pc(pc), .memStrobe(memStrobe),
    .memAddr(memAddr), .memWrite(memWrite), .bpMatch(bpMatch), .wpMatch(wpMatch)
  );
endmodule

// File: rtl/dbg_match_unit_chk.sv
module dbg_match_unit_chk (
  input logic clk,
  input logic rst_n,
  input logic pcValid,
  input logic memStrobe,
  input logic accessStall,
  input logic bpHit,
  input logic wpHit
);
  assert_stall_needs_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    accessStall |-> memStrobe);
  assert_stall_then_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    accessStall |=> wpHit);
  assert_hit_had_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wpHit |-> $past(accessStall));
  assert_single_report_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(wpHit && bpHit));
  assert_bp_needs_fetch_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bpHit |-> $past(pcValid));
endmodule

bind dbg_match_unit dbg_match_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pcValid(pcValid), .memStrobe(memStrobe),
  .accessStall(accessStall), .bpHit(bpHit), .wpHit(wpHit)
);

// File: tb/dbg_match_unit_tb.sv
`timescale 1ns/1ps
module dbg_match_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfgWe = 1'b0, cfgSel = 1'b0;
  logic [1:0]  cfgIdx = '0;
  logic [31:0] cfgAddr = '0;
  logic [1:0]  cfgKind = '0;
  logic        pcValid = 1'b0;
  logic [31:0] pc = '0;
  logic        memStrobe = 1'b0;
  logic [31:0] memAddr = '0;
  logic        memWrite = 1'b0;
  logic        accessStall, bpHit, wpHit;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  dbg_match_unit u_dut (
    .clk(clk), .rst_n(rst_n), .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgIdx(cfgIdx),
    .cfgAddr(cfgAddr), .cfgKind(cfgKind), .pcValid(pcValid), .pc(pc),
    .memStrobe(memStrobe), .memAddr(memAddr), .memWrite(memWrite),
    .accessStall(accessStall), .bpHit(bpHit), .wpHit(wpHit)
  );

  task automatic check(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  // entered at a falling edge; leaves at the next falling edge with inputs idle
  task automatic cfg(input logic sel, input logic [1:0] idx, input logic [31:0] a, input logic [1:0] k);
    cfgWe = 1'b1; cfgSel = sel; cfgIdx = idx; cfgAddr = a; cfgKind = k;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic probe(input string req, input logic pv, input logic [31:0] p,
                       input logic ms, input logic [31:0] ma, input logic mw,
                       input logic eStall, input logic eBp, input logic eWp);
    pcValid = pv; pc = p; memStrobe = ms; memAddr = ma; memWrite = mw;
    #1 check(req, "accessStall", accessStall, eStall);
    @(negedge clk);
    check(req, "bpHit", bpHit, eBp);
    check(req, "wpHit", wpHit, eWp);
    pcValid = 1'b0; memStrobe = 1'b0;
  endtask

  task automatic t_reset;
    check("R1", "bpHit at reset", bpHit, 1'b0);
    check("R1", "wpHit at reset", wpHit, 1'b0);
    probe("R1", 1'b1, 32'h0, 1'b1, 32'h0, 1'b1, 1'b0, 1'b0, 1'b0);
    probe("R1", 1'b1, 32'h0, 1'b1, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_breakpoint;
    cfg(1'b0, 2'd1, 32'h1000, 2'b01);
    probe("R2", 1'b1, 32'h1000, 1'b0, 32'h0, 1'b0, 1'b0, 1'b1, 1'b0);
    probe("R2", 1'b0, 32'h0, 1'b0, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0);
    probe("R5", 1'b1, 32'h1001, 1'b0, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0);
    probe("R5", 1'b1, 32'h0FFF, 1'b0, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0);
    probe("R9", 1'b0, 32'h1000, 1'b0, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_remove;
    cfg(1'b0, 2'd2, 32'h0, 2'b00);
    probe("R3", 1'b1, 32'h1000, 1'b0, 32'h0, 1'b0, 1'b0, 1'b1, 1'b0);
    cfg(1'b0, 2'd1, 32'h1000, 2'b00);
    probe("R3", 1'b1, 32'h1000, 1'b0, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_kinds;
    cfg(1'b1, 2'd0, 32'h2000, 2'b01);
    probe("R4", 1'b0, 32'h0, 1'b1, 32'h2000, 1'b0, 1'b1, 1'b0, 1'b1);
    probe("R7", 1'b0, 32'h0, 1'b0, 32'h2000, 1'b0, 1'b0, 1'b0, 1'b0);
    probe("R4", 1'b0, 32'h0, 1'b1, 32'h2000, 1'b1, 1'b0, 1'b0, 1'b0);
    cfg(1'b1, 2'd0, 32'h2000, 2'b10);
    probe("R4", 1'b0, 32'h0, 1'b1, 32'h2000, 1'b1, 1'b1, 1'b0, 1'b1);
    probe("R4", 1'b0, 32'h0, 1'b1, 32'h2000, 1'b0, 1'b0, 1'b0, 1'b0);
    cfg(1'b1, 2'd0, 32'h2000, 2'b11);
    probe("R6", 1'b0, 32'h0, 1'b1, 32'h2000, 1'b0, 1'b1, 1'b0, 1'b1);
    probe("R6", 1'b0, 32'h0, 1'b1, 32'h2000, 1'b1, 1'b1, 1'b0, 1'b1);
    probe("R5", 1'b0, 32'h0, 1'b1, 32'h2001, 1'b0, 1'b0, 1'b0, 1'b0);
    probe("R5", 1'b0, 32'h0, 1'b1, 32'h1FFF, 1'b1, 1'b0, 1'b0, 1'b0);
    probe("R9", 1'b0, 32'h0, 1'b0, 32'h2000, 1'b1, 1'b0, 1'b0, 1'b0);
    cfg(1'b1, 2'd0, 32'h2000, 2'b00);
    probe("R4", 1'b0, 32'h0, 1'b1, 32'h2000, 1'b0, 1'b0, 1'b0, 1'b0);
    probe("R4", 1'b0, 32'h0, 1'b1, 32'h2000, 1'b1, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_priority;
    cfg(1'b0, 2'd3, 32'h3000, 2'b11);
    cfg(1'b1, 2'd3, 32'h4000, 2'b11);
    probe("R8", 1'b1, 32'h3000, 1'b1, 32'h4000, 1'b1, 1'b1, 1'b0, 1'b1);
    probe("R8", 1'b1, 32'h3000, 1'b0, 32'h4000, 1'b1, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_timing;
    // the write cycle still compares against the old, disarmed slot 2
    cfgWe = 1'b1; cfgSel = 1'b1; cfgIdx = 2'd2; cfgAddr = 32'h5000; cfgKind = 2'b01;
    memStrobe = 1'b1; memAddr = 32'h5000; memWrite = 1'b0;
    #1 check("R10", "accessStall in write cycle", accessStall, 1'b0);
    @(negedge clk);
    cfgWe = 1'b0;
    check("R10", "wpHit after write cycle", wpHit, 1'b0);
    probe("R10", 1'b0, 32'h0, 1'b1, 32'h5000, 1'b0, 1'b1, 1'b0, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_breakpoint();
    t_remove();
    t_kinds();
    t_priority();
    t_timing();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule